// File: doc/BRIEF.md
# Write-Only I2C Register Target

This block is an I2C target that only accepts writes. It sits on a two-wire bus and lands the bytes a controller sends into a bank of sixteen 8-bit registers. The block does not run in the SCL domain. It samples SCL and SDA with its own system clock, passes each line through two flops, and finds bus events by comparing each synchronized sample with the one before it. It answers only to the 7-bit device address 1110100 with the direction bit low. It acknowledges by asserting an open-drain enable, which the pad uses to pull SDA low.

A transfer has three parts in a fixed order: the address byte, a register-select byte, and then any number of data bytes. Each byte is acknowledged. Each data byte is written into the register that the register-select byte chose, and the pointer steps up by one after every byte. Each commit is also shown for one cycle on a write strobe, together with its index and value. All sixteen registers are visible in parallel at all times.

Top module: `i2c_wr_target`

## Requirements
- R1: After reset, `sda_oe` is low, `wr_stb` is low and every register reads 0.
- R2: A start condition is SDA falling while SCL is high. It restarts byte reception at the address byte. This also applies in the middle of a transfer: a partly received byte is dropped and nothing from it is written.
- R3: A stop condition is SDA rising while SCL is high. It returns the block to idle. After a stop and before the next start, the block neither acknowledges nor writes any bytes clocked on the bus.
- R4: The first byte after a start is received MSB first. It is acknowledged when it equals 1110100 followed by a 0 direction bit (0xE8). `sda_oe` goes high three clock cycles after SCL falls at the end of the eighth bit, and goes low three cycles after SCL falls at the end of the ninth clock.
- R5: If the address byte carries any other 7-bit address, no acknowledge is given. The rest of the transfer, up to the next start, changes no register.
- R6: If the address matches but the direction bit is 1 (a read request, 0xE9), no acknowledge is given. The rest of the transfer changes no register.
- R7: The second byte is acknowledged. Its low 4 bits set the register pointer, and its upper bits are ignored. The byte itself is not stored in any register.
- R8: Every byte after the second is acknowledged. It is stored, MSB first as received, into the register the pointer selects.
- R9: The pointer steps up by one after each stored byte and wraps from 15 to 0.
- R10: `wr_stb` is high for exactly one cycle per stored byte, in the same cycle that `sda_oe` rises for that byte, with `wr_idx` and `wr_data` giving the target register and value. The register output shows the new value one cycle later.
- R11: `sda_oe` is low at all times outside an acknowledge slot: while idle, during the eight bits of any byte, and throughout refused transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | High to pull SDA low (acknowledge) |
| regs_flat | output | 128 | Register bank, register k at bits [8k+7:8k] |
| wr_stb | output | 1 | One-cycle pulse per stored data byte |
| wr_idx | output | 4 | Register index of the byte being stored |
| wr_data | output | 8 | Value of the byte being stored |

## Verification
The bound checker watches the following on every cycle:
- a start or stop always leaves SDA released on the next cycle;
- the enable only ever rises while synchronized SCL is low;
- the write strobe lasts one cycle and coincides with an acknowledge;
- each strobed value appears in its register on the next cycle;
- consecutive strobes in one transfer step the index by one, modulo 16.

Some properties need whole transfers to show them, so only the bench scenarios cover them:
- address matching, and refusal of a foreign address or a read bit;
- that the register-select byte is not stored, and that its upper bits are masked;
- that a partial byte cut off by a repeated start is dropped;
- that bytes clocked after a stop are ignored.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int N_LINES = 2;
    localparam int LN_SCL  = 1;
    localparam int LN_SDA  = 0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEVADDR,
        PH_REGSEL,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2c_wr_sync.sv
module i2c_wr_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
        logic [W-1:0] last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = raw;
        sync_d.stab = sync_q.meta;
        sync_d.last = sync_q.stab;
    end

    // Idle bus is high on both lines: reset to 1 so no false edge appears.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_line
        assign lvl[g]  = sync_q.stab[g];
        assign prev[g] = sync_q.last[g];
    end

endmodule

// File: rtl/i2c_wr_cond.sv
module i2c_wr_cond
    import i2c_wr_pkg::*;
(
    input  logic [N_LINES-1:0] lvl,
    input  logic [N_LINES-1:0] prev,
    output bus_ev_t            ev
);

    logic scl_now, scl_was, sda_now, sda_was, scl_held;

    always_comb begin
        scl_now  = lvl[LN_SCL];
        scl_was  = prev[LN_SCL];
        sda_now  = lvl[LN_SDA];
        sda_was  = prev[LN_SDA];
        scl_held = scl_now & scl_was;

        ev.start = scl_held & sda_was & ~sda_now;
        ev.stop  = scl_held & ~sda_was & sda_now;
        ev.rise  = scl_now & ~scl_was;
        ev.fall  = ~scl_now & scl_was;
        ev.sda   = sda_now;
    end

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import i2c_wr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b1110100,
    parameter int                NREG     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  bus_ev_t                 ev,
    output logic                    sda_oe,
    output logic                    wr_stb,
    output logic [$clog2(NREG)-1:0] wr_idx,
    output logic [BYTE_W-1:0]       wr_data
);

    localparam int                IW         = $clog2(NREG);
    localparam int                BCW        = $clog2(BYTE_W + 1);
    localparam logic [BCW-1:0]    BITS_FULL  = BCW'(BYTE_W);
    localparam logic [BYTE_W-1:0] ADDR_WRITE = {DEV_ADDR, 1'b0};

    typedef struct packed {
        phase_e            ph;
        logic [BCW-1:0]    bits;
        logic [BYTE_W-1:0] sh;
        logic              ack;
        logic              oe;
        logic [IW-1:0]     ptr;
        logic              stb;
        logic [IW-1:0]     widx;
        logic [BYTE_W-1:0] wdat;
    } fsm_t;

    fsm_t st_d, st_q;
    logic listening;

    always_comb begin
        listening = (st_q.ph == PH_DEVADDR) || (st_q.ph == PH_REGSEL) ||
                    (st_q.ph == PH_DATA);
        st_d      = st_q;
        st_d.stb  = 1'b0;

        if (ev.start) begin
            st_d.ph   = PH_DEVADDR;
            st_d.bits = '0;
            st_d.ack  = 1'b0;
            st_d.oe   = 1'b0;
        end else if (ev.stop) begin
            st_d.ph   = PH_IDLE;
            st_d.bits = '0;
            st_d.ack  = 1'b0;
            st_d.oe   = 1'b0;
        end else if (listening) begin
            if (st_q.ack) begin
                // ninth clock: hold SDA low until its falling edge
                if (ev.fall) begin
                    st_d.ack  = 1'b0;
                    st_d.oe   = 1'b0;
                    st_d.bits = '0;
                end
            end else if (ev.rise) begin
                st_d.sh   = {st_q.sh[BYTE_W-2:0], ev.sda};
                st_d.bits = st_q.bits + 1'b1;
            end else if (ev.fall && (st_q.bits == BITS_FULL)) begin
                st_d.bits = '0;
                unique case (st_q.ph)
                    PH_DEVADDR: begin
                        if (st_q.sh == ADDR_WRITE) begin
                            st_d.ack = 1'b1;
                            st_d.oe  = 1'b1;
                            st_d.ph  = PH_REGSEL;
                        end else begin
                            st_d.ph  = PH_SKIP;
                        end
                    end
                    PH_REGSEL: begin
                        st_d.ptr = st_q.sh[IW-1:0];
                        st_d.ack = 1'b1;
                        st_d.oe  = 1'b1;
                        st_d.ph  = PH_DATA;
                    end
                    PH_DATA: begin
                        st_d.stb  = 1'b1;
                        st_d.widx = st_q.ptr;
                        st_d.wdat = st_q.sh;
                        st_d.ptr  = st_q.ptr + 1'b1;
                        st_d.ack  = 1'b1;
                        st_d.oe   = 1'b1;
                    end
                    default: begin
                        st_d.ph = PH_SKIP;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe  = st_q.oe;
    assign wr_stb  = st_q.stb;
    assign wr_idx  = st_q.widx;
    assign wr_data = st_q.wdat;

endmodule

// File: rtl/i2c_wr_regs.sv
module i2c_wr_regs #(
    parameter int NREG = 16,
    parameter int DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] widx,
    input  logic [DW-1:0]           wdat,
    output logic [NREG*DW-1:0]      flat
);

    localparam int IW = $clog2(NREG);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (we && (widx == IW'(g))) begin
                r_d = wdat;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        assign flat[g*DW +: DW] = r_q;
    end

endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2c_wr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b1110100,
    parameter int                NREG     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_in,
    input  logic                    sda_in,
    output logic                    sda_oe,
    output logic [NREG*BYTE_W-1:0]  regs_flat,
    output logic                    wr_stb,
    output logic [$clog2(NREG)-1:0] wr_idx,
    output logic [BYTE_W-1:0]       wr_data
);

    logic [N_LINES-1:0] raw_lines, lvl, prev;
    bus_ev_t            ev;
    logic               scl_s, start_det, stop_det;

    always_comb begin
        raw_lines         = '1;
        raw_lines[LN_SCL] = scl_in;
        raw_lines[LN_SDA] = sda_in;
    end

    i2c_wr_sync #(.W(N_LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_lines),
        .lvl  (lvl),
        .prev (prev)
    );

    i2c_wr_cond u_cond (
        .lvl (lvl),
        .prev(prev),
        .ev  (ev)
    );

    assign scl_s     = lvl[LN_SCL];
    assign start_det = ev.start;
    assign stop_det  = ev.stop;

    i2c_wr_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .sda_oe (sda_oe),
        .wr_stb (wr_stb),
        .wr_idx (wr_idx),
        .wr_data(wr_data)
    );

    i2c_wr_regs #(.NREG(NREG), .DW(BYTE_W)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_stb),
        .widx (wr_idx),
        .wdat (wr_data),
        .flat (regs_flat)
    );

endmodule

// File: rtl/i2c_wr_chk.sv
module i2c_wr_chk #(
    parameter int NREG = 16,
    parameter int DW   = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_s,
    input logic                    start_det,
    input logic                    stop_det,
    input logic                    sda_oe,
    input logic                    wr_stb,
    input logic [$clog2(NREG)-1:0] wr_idx,
    input logic [DW-1:0]           wr_data,
    input logic [NREG*DW-1:0]      regs_flat
);

    localparam int IW = $clog2(NREG);

    logic          pend_q, seen_q;
    logic [IW-1:0] lidx_q;
    logic [DW-1:0] ldat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            seen_q <= 1'b0;
            lidx_q <= '0;
            ldat_q <= '0;
        end else begin
            pend_q <= wr_stb;
            if (wr_stb) begin
                lidx_q <= wr_idx;
                ldat_q <= wr_data;
            end
            if (start_det) begin
                seen_q <= 1'b0;
            end else if (wr_stb) begin
                seen_q <= 1'b1;
            end
        end
    end

    a_r2_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    a_r3_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    a_r4_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    a_r10_strobe_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> sda_oe);

    a_r8_value_lands: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (regs_flat[int'(lidx_q)*DW +: DW] == ldat_q));

    a_r9_pointer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && seen_q) |-> (wr_idx == IW'(lidx_q + 1'b1)));

endmodule

bind i2c_wr_target i2c_wr_chk #(.NREG(NREG), .DW(i2c_wr_pkg::BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .regs_flat(regs_flat)
);

// File: tb/tb_i2c_wr_target.sv
module tb_i2c_wr_target;

    localparam int NREG = 16;
    localparam int DW   = 8;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [NREG*DW-1:0] regs_flat;
    logic wr_stb;
    logic [3:0] wr_idx;
    logic [7:0] wr_data;

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_wr_target dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_bus),
        .sda_oe   (sda_oe),
        .regs_flat(regs_flat),
        .wr_stb   (wr_stb),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    int    errors = 0;
    int    checks = 0;
    bit    run    = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    // behavioural reference: expected outputs and model state
    logic       exp_oe   = 1'b0;
    logic       exp_stb  = 1'b0;
    logic [3:0] exp_idx  = '0;
    logic [7:0] exp_data = '0;
    logic [7:0] exp_regs [NREG];
    int   mstate = 0;            // 0 idle, 1 address, 2 register select, 3 data, 4 ignore
    int   ptr    = 0;
    bit   pend_ack, pend_stb;
    int   pend_idx;
    logic [7:0] pend_data;
    int   ack_cnt = 0;
    int   stb_cnt = 0;
    logic oe_prev = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic logic [7:0] reg_at(input int k);
        return regs_flat[k*DW +: DW];
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && run) begin
            check(sda_oe === exp_oe, exp_oe ? cur_req : "R11", "sda_oe", sda_oe, exp_oe);
            check(wr_stb === exp_stb, "R10", "wr_stb", wr_stb, exp_stb);
            if (exp_stb) begin
                check(wr_idx === exp_idx, "R10", "wr_idx", wr_idx, exp_idx);
                check(wr_data === exp_data, "R10", "wr_data", wr_data, exp_data);
            end
            for (int k = 0; k < NREG; k++) begin
                check(reg_at(k) === exp_regs[k], cur_req, $sformatf("reg%0d", k),
                      reg_at(k), exp_regs[k]);
            end
            if (sda_oe && !oe_prev) ack_cnt++;
            if (wr_stb) stb_cnt++;
            oe_prev = sda_oe;
        end
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // SCL falls at a negedge; kind 1 ends a byte, kind 2 ends an acknowledge
    task automatic fall_scl(input int kind);
        scl_m = 1'b0;
        if (kind == 0) begin
            wait_neg(4);
        end else begin
            repeat (3) @(posedge clk);
            #1;
            if (kind == 1) begin
                exp_oe   = pend_ack;
                exp_stb  = pend_stb;
                exp_idx  = pend_idx[3:0];
                exp_data = pend_data;
            end else begin
                exp_oe = 1'b0;
            end
            @(posedge clk);
            #1;
            exp_stb = 1'b0;
            if (kind == 1 && pend_stb) exp_regs[pend_idx] = pend_data;
            @(negedge clk);
        end
    endtask

    task automatic do_start();
        sda_m = 1'b1;
        wait_neg(4);
        scl_m = 1'b1;
        wait_neg(8);
        sda_m  = 1'b0;
        mstate = 1;
        wait_neg(8);
        fall_scl(0);
    endtask

    task automatic do_stop();
        sda_m = 1'b0;
        wait_neg(4);
        scl_m = 1'b1;
        wait_neg(8);
        sda_m  = 1'b1;
        mstate = 0;
        wait_neg(8);
    endtask

    task automatic put_byte(input logic [7:0] b);
        pend_ack = 1'b0;
        pend_stb = 1'b0;
        case (mstate)
            1: begin
                if (b == 8'hE8) begin pend_ack = 1'b1; mstate = 2; end
                else mstate = 4;
            end
            2: begin ptr = b % 16; pend_ack = 1'b1; mstate = 3; end
            3: begin
                pend_ack = 1'b1; pend_stb = 1'b1;
                pend_idx = ptr; pend_data = b;
                ptr = (ptr + 1) % 16;
            end
            default: ;
        endcase
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            wait_neg(4);
            scl_m = 1'b1;
            wait_neg(8);
            fall_scl(i == 0 ? 1 : 0);
        end
        sda_m = 1'b1;
        wait_neg(4);
        scl_m = 1'b1;
        wait_neg(8);
        fall_scl(2);
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i];
            wait_neg(4);
            scl_m = 1'b1;
            wait_neg(8);
            fall_scl(0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        int a0, s0;
        for (int k = 0; k < NREG; k++) exp_regs[k] = '0;
        wait_neg(5);
        // R1: reset state
        check(sda_oe === 1'b0, "R1", "sda_oe in reset", sda_oe, 0);
        check(wr_stb === 1'b0, "R1", "wr_stb in reset", wr_stb, 0);
        check(regs_flat === '0, "R1", "regs in reset", regs_flat[63:0], 0);
        rst_n = 1'b1;
        wait_neg(4);
        run = 1'b1;
        check(sda_oe === 1'b0, "R1", "sda_oe after reset", sda_oe, 0);

        // R4 R7 R8 R10: plain write of two bytes starting at register 3
        cur_req = "R8";
        a0 = ack_cnt; s0 = stb_cnt;
        do_start();
        put_byte(8'hE8);
        put_byte(8'h03);
        put_byte(8'hA5);
        put_byte(8'h3C);
        do_stop();
        check(ack_cnt - a0 == 4, "R4", "acknowledges", ack_cnt - a0, 4);
        check(stb_cnt - s0 == 2, "R10", "strobes", stb_cnt - s0, 2);
        check(reg_at(3) == 8'hA5, "R8", "reg3", reg_at(3), 8'hA5);
        check(reg_at(4) == 8'h3C, "R9", "reg4", reg_at(4), 8'h3C);
        check(reg_at(5) == 8'h00, "R7", "reg5 untouched", reg_at(5), 0);

        // R9 R7: upper bits of the select byte masked, pointer wraps 15 -> 0
        cur_req = "R9";
        do_start();
        put_byte(8'hE8);
        put_byte(8'h2F);
        put_byte(8'h11);
        put_byte(8'h22);
        put_byte(8'h33);
        do_stop();
        check(reg_at(15) == 8'h11, "R7", "reg15", reg_at(15), 8'h11);
        check(reg_at(0) == 8'h22, "R9", "reg0 after wrap", reg_at(0), 8'h22);
        check(reg_at(1) == 8'h33, "R9", "reg1 after wrap", reg_at(1), 8'h33);

        // R5: foreign address refused
        cur_req = "R5";
        a0 = ack_cnt; s0 = stb_cnt;
        do_start();
        put_byte(8'hEA);
        put_byte(8'h02);
        put_byte(8'h77);
        do_stop();
        check(ack_cnt == a0, "R5", "no acknowledge", ack_cnt - a0, 0);
        check(stb_cnt == s0, "R5", "no strobe", stb_cnt - s0, 0);
        check(reg_at(2) == 8'h00, "R5", "reg2", reg_at(2), 0);

        // R6: read request refused
        cur_req = "R6";
        a0 = ack_cnt; s0 = stb_cnt;
        do_start();
        put_byte(8'hE9);
        put_byte(8'h02);
        put_byte(8'h55);
        do_stop();
        check(ack_cnt == a0, "R6", "no acknowledge", ack_cnt - a0, 0);
        check(reg_at(2) == 8'h00, "R6", "reg2", reg_at(2), 0);
        check(stb_cnt == s0, "R11", "no strobe on refusal", stb_cnt - s0, 0);

        // R2: repeated start cuts a partial byte
        cur_req = "R2";
        a0 = ack_cnt;
        do_start();
        put_byte(8'hE8);
        put_byte(8'h06);
        put_byte(8'h99);
        put_bits(8'hFF, 3);
        do_start();
        put_byte(8'hE8);
        put_byte(8'h08);
        put_byte(8'h42);
        do_stop();
        check(ack_cnt - a0 == 6, "R2", "acknowledges", ack_cnt - a0, 6);
        check(reg_at(6) == 8'h99, "R2", "reg6", reg_at(6), 8'h99);
        check(reg_at(7) == 8'h00, "R2", "reg7 partial dropped", reg_at(7), 0);
        check(reg_at(8) == 8'h42, "R2", "reg8", reg_at(8), 8'h42);

        // R3: bytes clocked after a stop are ignored
        cur_req = "R3";
        a0 = ack_cnt; s0 = stb_cnt;
        do_start();
        put_byte(8'hE8);
        put_byte(8'h0A);
        do_stop();
        fall_scl(0);
        put_byte(8'h5A);
        put_byte(8'h5B);
        do_stop();
        check(ack_cnt - a0 == 2, "R3", "acknowledges", ack_cnt - a0, 2);
        check(stb_cnt == s0, "R3", "no strobe after stop", stb_cnt - s0, 0);
        check(reg_at(10) == 8'h00, "R3", "reg10", reg_at(10), 0);
        check(reg_at(11) == 8'h00, "R3", "reg11", reg_at(11), 0);

        wait_neg(10);
        finish_up();
    end

endmodule